// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a synchronous sequencer that connects a simple host request port to an external asynchronous static RAM. The host presents one word per request, with an address, a direction bit and write data. The controller then drives the memory address pins, the active-low write and output strobes, and the data pins until that single access is complete. The data pins are brought out as a pad-style triple: an output value, a drive enable and an input value. A pad ring, or the bench, resolves the shared bus from these.

Each phase of an access lasts a parameterised number of clock cycles. A write has address-and-data setup, strobe width and hold. A read has its access delay. Parameterising the phases lets one netlist fit memories of different speed grades. While an access is in progress, `ready_o` is low and requests are ignored. A read returns its word on `rdata_o`, qualified by a one-cycle `rvalid_o` pulse.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it, `sram_we_no`=1, `sram_oe_no`=1, `dq_oe_o`=0, `rvalid_o`=0 and `ready_o`=1. Reset takes effect immediately, even in the middle of an access.
- R2: `dq_oe_o` is 1 only while `sram_oe_no` is 1. The data pins are driven only during the write phases (setup, strobe, hold) and are released during reads and idle.
- R3: `sram_we_no` and `sram_oe_no` are never both 0 in any cycle.
- R4: A write presents the latched address on `sram_addr_o` and the latched data on `dq_o` with `dq_oe_o`=1 for exactly SETUP_CYC cycles with `sram_we_no`=1. Then `sram_we_no` is 0 for exactly STROBE_CYC cycles, with address and data unchanged.
- R5: After `sram_we_no` returns to 1, address and data stay driven with `dq_oe_o`=1 for exactly HOLD_CYC cycles. Then the bus is released.
- R6: A read holds `sram_oe_no`=0 for exactly ACCESS_CYC cycles with a constant address. The word on `dq_i` is captured at the clock edge that ends the last of those cycles.
- R7: `rvalid_o` is 1 for exactly one cycle, the cycle after a read's last access cycle, with `rdata_o` equal to the captured word. It is 0 in every other cycle.
- R8: `ready_o` is 0 from the cycle after acceptance until the access ends. This is SETUP_CYC+STROBE_CYC+HOLD_CYC cycles for a write and ACCESS_CYC cycles for a read. Requests made while `ready_o` is 0 have no effect.
- R9: In the cycle that `ready_o` returns to 1, both strobes are 1 and `dq_oe_o` is 0. This gives at least one fully released cycle between consecutive accesses.
- R10: A request is accepted at a rising clock edge where `req_i`=1 and `ready_o`=1. `we_i`=1 selects a write and `we_i`=0 a read. With `req_i`=0 the controller stays idle with both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host word address |
| wdata_i | input | DATA_W | Host write data |
| ready_o | output | 1 | Idle, request may be accepted |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | One-cycle read data qualifier |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| dq_o | output | DATA_W | Data pin output value |
| dq_oe_o | output | 1 | Data pin drive enable |
| dq_i | input | DATA_W | Data pin input value |

## Verification
Writes and reads are tried with all-zero, all-one, alternating and mixed data at the lowest, highest and scattered addresses. This separates a stuck or swapped data path from an address path fault. The memory model returns a junk word until the access delay has elapsed, so a read captured one cycle early is told apart from a correct one. Requests issued while the controller is busy, and a reset asserted in the middle of a write strobe, show whether the sequencer ignores stray requests and releases the pins immediately. Reading back untouched locations shows that no extra write happened.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WSTROBE = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_RACCESS = 3'd4
  } sram_state_e;
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);

  // R8: counter never wraps below zero
  a_r8_cnt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3,
  parameter int CW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          done_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output sram_state_e   state_o
);
  localparam logic [CW-1:0] SetupLd  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] StrobeLd = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HoldLd   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] AccessLd = CW'(ACCESS_CYC - 1);

  sram_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        load_o     = 1'b1;
        state_d    = we_i ? ST_WSETUP : ST_RACCESS;
        load_val_o = we_i ? SetupLd : AccessLd;
      end
      ST_WSETUP: if (done_i) begin
        state_d = ST_WSTROBE; load_o = 1'b1; load_val_o = StrobeLd;
      end
      ST_WSTROBE: if (done_i) begin
        state_d = ST_WHOLD; load_o = 1'b1; load_val_o = HoldLd;
      end
      ST_WHOLD: if (done_i) state_d = ST_IDLE;
      ST_RACCESS: if (done_i) begin
        state_d = ST_IDLE; capture_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R10: acceptance only from idle
  a_r10_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (state_q == ST_WSETUP || state_q == ST_RACCESS));
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end

  // R7: rvalid is a single-cycle pulse
  a_r7_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int MaxAB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MaxCD = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MaxC  = (MaxAB > MaxCD) ? MaxAB : MaxCD;
  localparam int CW    = $clog2(MaxC) + 1;

  initial begin
    if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1 || ACCESS_CYC < 1)
      $error("sram_ctrl: phase lengths must be at least 1");
  end

  sram_state_e   state;
  logic          load, done, accept, capture;
  logic [CW-1:0] load_val;

  sram_seq #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC), .CW(CW)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i,
    .done_i(done), .load_o(load), .load_val_o(load_val),
    .accept_o(accept), .capture_o(capture), .state_o(state)
  );

  sram_wait_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .done_o(done)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk_i, .rst_ni, .accept_i(accept), .capture_i(capture),
    .addr_i, .wdata_i, .dq_i,
    .addr_o(sram_addr_o), .wdata_o(dq_o), .rdata_o, .rvalid_o
  );

  // pin decode from the state register only
  assign ready_o    = (state == ST_IDLE);
  assign sram_we_no = (state != ST_WSTROBE);
  assign sram_oe_no = (state != ST_RACCESS);
  assign dq_oe_o    = (state == ST_WSETUP) || (state == ST_WSTROBE) || (state == ST_WHOLD);

  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));

  a_r2_bus_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> sram_oe_no);

  a_r4_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> ($past(dq_oe_o) && $stable(sram_addr_o) && $stable(dq_o)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (dq_oe_o && $stable(sram_addr_o) && $stable(dq_o)));

  a_r6_read_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_oe_no && !$past(sram_oe_no)) |-> $stable(sram_addr_o));

  a_r7_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (sram_oe_no && !$past(sram_oe_no)));

  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_we_no && sram_oe_no && !dq_oe_o));
endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 16;
  localparam int S = 2, W = 2, H = 1, A = 3;
  localparam logic [DW-1:0] JUNK = 16'hDEAD;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready_o, rvalid_o, sram_we_no, sram_oe_no, dq_oe_o;
  logic [DW-1:0] rdata_o, dq_o, dq_i;
  logic [AW-1:0] sram_addr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .STROBE_CYC(W),
              .HOLD_CYC(H), .ACCESS_CYC(A)) dut_i (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o, .rdata_o, .rvalid_o, .sram_addr_o, .sram_we_no, .sram_oe_no,
    .dq_o, .dq_oe_o, .dq_i);

  // behavioural memory: junk until access delay has elapsed
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];
  int oe_cnt = 0;
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = {i[7:0], ~i[7:0]};
    exp_mem[i] = {i[7:0], ~i[7:0]};
  end
  always @(posedge clk) begin
    if (!sram_we_no && dq_oe_o) mem[sram_addr_o] <= dq_o;
    if (!sram_oe_no) oe_cnt <= oe_cnt + 1; else oe_cnt <= 0;
  end
  assign dq_i = (!sram_oe_no && oe_cnt >= A-1) ? mem[sram_addr_o] : JUNK;

  int n_chk = 0, n_bad = 0, r3_bad = 0, r2_bad = 0;
  bit finished = 0;

  always @(negedge clk) if (rst_ni) begin
    if (!sram_we_no && !sram_oe_no) r3_bad++;
    if (dq_oe_o && (!sram_oe_no)) r2_bad++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  task automatic do_op(input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit poke);
    int busy = 0, su = 0, st = 0, ho = 0, ac = 0, abad = 0, dbad = 0;
    chk(ready_o, "R10 ready before request", ready_o, 1);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!ready_o) begin
      busy++;
      if (poke && busy == 1) begin req = 1'b1; we = 1'b1; addr = a ^ 8'h80; wdata = 16'hFFFF; end
      if (poke && busy == 2) req = 1'b0;
      if (sram_addr_o != a) abad++;
      if (w) begin
        if (dq_oe_o && dq_o != d) dbad++;
        if (!sram_we_no) st++;
        else if (dq_oe_o) begin if (st == 0) su++; else ho++; end
      end else if (!sram_oe_no) ac++;
      @(negedge clk);
    end
    chk(busy == (w ? S+W+H : A), "R8 busy length", busy, w ? S+W+H : A);
    chk(abad == 0, "R4/R6 address stable", abad, 0);
    if (w) begin
      chk(su == S, "R4 setup cycles", su, S);
      chk(st == W, "R4 strobe cycles", st, W);
      chk(ho == H, "R5 hold cycles", ho, H);
      chk(dbad == 0, "R4 data stable", dbad, 0);
      exp_mem[a] = d;
    end else begin
      chk(ac == A, "R6 access cycles", ac, A);
      chk(rvalid_o, "R7 rvalid pulse", rvalid_o, 1);
      chk(rdata_o == exp_mem[a], "R6 read data", rdata_o, exp_mem[a]);
    end
    chk(sram_we_no && sram_oe_no && !dq_oe_o, "R9 released gap",
        {sram_we_no, sram_oe_no, dq_oe_o}, 3'b110);
    @(negedge clk);
    chk(!rvalid_o, "R7 rvalid single cycle", rvalid_o, 0);
  endtask

  typedef struct packed { logic w; logic [AW-1:0] a; logic [DW-1:0] d; } vec_t;
  localparam vec_t [0:11] VECS = '{
    '{1'b1, 8'h00, 16'h0000}, '{1'b1, 8'hFF, 16'hFFFF},
    '{1'b1, 8'h5A, 16'hA5A5}, '{1'b1, 8'h01, 16'h1234},
    '{1'b0, 8'h00, 16'h0000}, '{1'b0, 8'hFF, 16'h0000},
    '{1'b0, 8'h5A, 16'h0000}, '{1'b0, 8'h01, 16'h0000},
    '{1'b0, 8'h33, 16'h0000}, '{1'b1, 8'h5A, 16'h5A5A},
    '{1'b0, 8'h5A, 16'h0000}, '{1'b0, 8'hA5, 16'h0000}
  };

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sram_we_no && sram_oe_no && !dq_oe_o && !rvalid_o && ready_o, "R1 in reset",
        {sram_we_no, sram_oe_no, dq_oe_o, rvalid_o, ready_o}, 5'b11001);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sram_we_no && sram_oe_no && !dq_oe_o && !rvalid_o && ready_o, "R1 after reset",
        {sram_we_no, sram_oe_no, dq_oe_o, rvalid_o, ready_o}, 5'b11001);
    repeat (3) @(negedge clk);
    chk(ready_o && sram_we_no && sram_oe_no, "R10 idle without request",
        {ready_o, sram_we_no, sram_oe_no}, 3'b111);

    for (int i = 0; i < 12; i++) do_op(VECS[i].w, VECS[i].a, VECS[i].d, 1'b0);

    // back-to-back with requests during busy that must be ignored
    do_op(1'b1, 8'h10, 16'hC0DE, 1'b1);
    do_op(1'b0, 8'h90, 16'h0000, 1'b1);
    chk(rdata_o == {8'h90, 8'h6F}, "R8 busy request ignored", rdata_o, {8'h90, 8'h6F});
    do_op(1'b0, 8'h10, 16'h0000, 1'b0);

    // reset asserted during write strobe
    req = 1'b1; we = 1'b1; addr = 8'h77; wdata = 16'h7777;
    @(negedge clk); req = 1'b0;
    repeat (S) @(negedge clk);
    chk(!sram_we_no, "R4 strobe active before reset", sram_we_no, 0);
    rst_ni = 1'b0; #1;
    chk(sram_we_no && sram_oe_no && !dq_oe_o && ready_o, "R1 mid-access reset",
        {sram_we_no, sram_oe_no, dq_oe_o, ready_o}, 4'b1101);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    do_op(1'b0, 8'hFF, 16'h0000, 1'b0);

    chk(r3_bad == 0, "R3 strobes exclusive", r3_bad, 0);
    chk(r2_bad == 0, "R2 bus only driven with oe high", r2_bad, 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule